// File: doc/BRIEF.md
# Serial Character Transmitter with Programmable Idle Gap

The block serialises one 8-bit character at a time onto a single output line. Each frame is a low start bit, then the data bits least significant first, then an optional parity bit (even or odd), then a high stop bit. After the stop bit the block can keep the line high for a programmed number of extra bit periods (the guard gap) before it starts the next character. A single-entry holding register accepts the next character while the current one is still being shifted out, or while its gap is still running.

Everything on the line moves on a one-cycle bit-period tick supplied from outside. The ready flag tells the writer that the holding register is free. The empty flag tells it that no frame, gap or waiting character is left. Parity mode and gap length are captured when a character moves from the holding register into the shifter, so a change to them affects only later characters.

States: IDLE (line high), START (line low), DATA (one data bit per period), PARITY (parity bit), STOP (line high), GUARD (line high for the programmed count). Transitions, each taken on a tick: IDLE to START when a character is waiting. START to DATA. DATA to PARITY or STOP after the last data bit, depending on the captured parity enable. PARITY to STOP. STOP to GUARD when the captured gap is non-zero. STOP or GUARD (on the gap's last period) to START when a character is waiting, otherwise to IDLE.

Top module: `uart_tg_tx`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to IDLE. After that edge `txd`, `hold_ready` and `tx_empty` are all 1.
- R2: A frame is 0 (start), then `data[0]` through `data[7]`, then 1 (stop). Each bit lasts from one `bit_tick` to the next. The line changes in the clock cycle after the tick that starts a bit.
- R3: When the captured `par_en` is 1, one parity bit follows `data[7]`. With `par_odd`=0 it equals the XOR of the data bits (even parity). With `par_odd`=1 it is that XOR inverted (odd parity). When `par_en` is 0 there is no parity slot.
- R4: With a captured gap value N greater than 0, `txd` stays 1 for N bit periods after the stop bit before the next start bit. `guard_len` is captured when the character enters the shifter.
- R5: With a gap value of 0 and a character waiting, the next start bit follows the stop bit with no idle period between them.
- R6: `hold_ready` falls in the cycle after an accepted write. It rises in the cycle after the tick on which the held character moves into the shifter.
- R7: A write made while `hold_ready` is 0 is ignored. The held character and the line output are unchanged by it.
- R8: `tx_empty` is 1 only when no frame or gap is in progress and no character is held. It is 0 for the whole gap.
- R9: The line state and both flags change only on edges where `bit_tick` is 1, except for the fall of `hold_ready` on a write. `txd` is stable between ticks.
- R10: The gap value 255 is supported and gives 255 high bit periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| par_en | input | 1 | 1 adds a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| guard_len | input | 8 | Gap length in bit periods after the stop bit |
| txd | output | 1 | Serial line, idle high |
| hold_ready | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | No frame, gap or held character |

## Verification
The hardest case to reach is a transfer on the last tick of a frame: the stop bit with a zero gap, or the final gap period. For this to happen, the next character must already be in the holding register when that tick arrives. The stimulus writes the following character as soon as `hold_ready` rises, which is early in the current frame. This makes every later frame start at that last tick rather than from IDLE. One run uses a gap of 255 and one uses irregular tick spacing, so that the count boundaries and the tick gating are tested away from a fixed rhythm.

// File: rtl/uart_tg_pkg.sv
package uart_tg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4,
        ST_GUARD  = 3'd5
    } tx_state_e;
endpackage

// File: rtl/uart_tg_hold.sv
module uart_tg_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end

    // R7: a write while full leaves the held character alone
    a_r7_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !take) |=> (full && $stable(data)));

    // R6: after a take the register is free
    a_r6_free_after_take: assert property (@(posedge clk) disable iff (rst)
        take |=> !full);
endmodule

// File: rtl/uart_tg_fsm.sv
module uart_tg_fsm
    import uart_tg_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int GUARD_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_tick,
    input  logic               hold_full,
    input  logic [DATA_W-1:0]  hold_data,
    input  logic               par_en,
    input  logic               par_odd,
    input  logic [GUARD_W-1:0] guard_len,
    output logic               take,
    output logic               txd,
    output logic               idle
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
    localparam logic [GUARD_W-1:0] ONE_G = GUARD_W'(1);

    tx_state_e          state, state_nx;
    logic [DATA_W-1:0]  sh_q;
    logic [CNT_W-1:0]   bit_q;
    logic [GUARD_W-1:0] gap_q;
    logic [GUARD_W-1:0] gcnt_q;
    logic               par_en_q, par_bit_q;
    logic               run_q;

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (hold_full) state_nx = ST_START;
            ST_START:  state_nx = ST_DATA;
            ST_DATA:   if (bit_q == LAST_BIT) state_nx = par_en_q ? ST_PARITY : ST_STOP;
            ST_PARITY: state_nx = ST_STOP;
            ST_STOP: begin
                if (gap_q != '0)    state_nx = ST_GUARD;
                else if (hold_full) state_nx = ST_START;
                else                state_nx = ST_IDLE;
            end
            ST_GUARD: begin
                if (gcnt_q == ONE_G) state_nx = hold_full ? ST_START : ST_IDLE;
            end
            default:   state_nx = ST_IDLE;
        endcase
    end

    assign take = bit_tick && (state_nx == ST_START) && (state != ST_START);

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            sh_q      <= '0;
            bit_q     <= '0;
            gap_q     <= '0;
            gcnt_q    <= '0;
            par_en_q  <= 1'b0;
            par_bit_q <= 1'b0;
        end else if (bit_tick) begin
            state <= state_nx;
            if (take) begin
                sh_q      <= hold_data;
                gap_q     <= guard_len;
                par_en_q  <= par_en;
                par_bit_q <= (^hold_data) ^ par_odd;
                bit_q     <= '0;
            end else if (state == ST_DATA) begin
                sh_q  <= sh_q >> 1;
                bit_q <= bit_q + CNT_W'(1);
            end
            if (state == ST_STOP)       gcnt_q <= gap_q;
            else if (state == ST_GUARD) gcnt_q <= gcnt_q - ONE_G;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= 1'b1;
    end

    // outputs from the state
    always_comb begin
        unique case (state)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = sh_q[0];
            ST_PARITY: txd = par_bit_q;
            default:   txd = 1'b1;
        endcase
        idle = (state == ST_IDLE);
    end

    // R9: line only moves after a tick
    a_r9_txd_stable: assert property (@(posedge clk) disable iff (rst)
        (run_q && !$past(bit_tick)) |-> $stable(txd));

    // R2: a held character in IDLE starts a frame on the tick
    a_r2_load_start: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && bit_tick && hold_full) |=> (state == ST_START && !txd));

    // R4: the line is high throughout the gap
    a_r4_guard_high: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GUARD) |-> txd);
endmodule

// File: rtl/uart_tg_tx.sv
module uart_tg_tx #(
    parameter int DATA_W  = 8,
    parameter int GUARD_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_tick,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               par_en,
    input  logic               par_odd,
    input  logic [GUARD_W-1:0] guard_len,
    output logic               txd,
    output logic               hold_ready,
    output logic               tx_empty
);
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              fsm_idle;

    uart_tg_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    uart_tg_fsm #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .bit_tick  (bit_tick),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .guard_len (guard_len),
        .take      (take),
        .txd       (txd),
        .idle      (fsm_idle)
    );

    assign hold_ready = !hold_full;
    assign tx_empty   = fsm_idle && !hold_full;

    // R8: an empty transmitter always shows an idle line
    a_r8_empty_idle_line: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> txd);

    // R6: an accepted write makes the register busy next cycle
    a_r6_busy_after_write: assert property (@(posedge clk) disable iff (rst)
        (hold_ready && wr_en) |=> !hold_ready);
endmodule

// File: tb/test_uart_tg_tx.sv
module test_uart_tg_tx;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic [7:0] guard_len = '0;
    logic       txd, hold_ready, tx_empty;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int tick_period = 4;
    int tick_cnt = 0;
    bit done = 1'b0;
    string tag = "R1";

    // behavioural reference: bit queue plus one-deep holding slot
    bit       m_q[$];
    bit       m_full = 1'b0;
    bit [7:0] m_data = '0;

    uart_tg_tx i_uart_tg_tx (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .wr_en(wr_en),
        .wr_data(wr_data), .par_en(par_en), .par_odd(par_odd),
        .guard_len(guard_len), .txd(txd), .hold_ready(hold_ready),
        .tx_empty(tx_empty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        bit pre_full;
        pre_full = m_full;
        if (rst) begin
            m_q.delete();
            m_full = 1'b0;
        end else begin
            if (bit_tick) begin
                if (m_q.size() != 0) void'(m_q.pop_front());
                if (m_q.size() == 0 && m_full) begin
                    m_q.push_back(1'b0);
                    for (int i = 0; i < 8; i++) m_q.push_back(m_data[i]);
                    if (par_en) m_q.push_back((^m_data) ^ par_odd);
                    m_q.push_back(1'b1);
                    for (int i = 0; i < int'(guard_len); i++) m_q.push_back(1'b1);
                    m_full = 1'b0;
                end
            end
            if (wr_en && !pre_full) begin
                m_full = 1'b1;
                m_data = wr_data;
            end
        end
    end

    // tick generator, driven away from the active edge
    always @(negedge clk) begin
        #1;
        if (tick_cnt >= tick_period - 1) begin
            tick_cnt = 0;
            bit_tick = 1'b1;
        end else begin
            tick_cnt++;
            bit_tick = 1'b0;
        end
    end

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        cycles++;
        if (!rst && !done) begin
            check(tag, txd, (m_q.size() != 0) ? m_q[0] : 1'b1, "txd");
            check(tag, hold_ready, !m_full, "hold_ready");
            check(tag, tx_empty, (m_q.size() == 0) && !m_full, "tx_empty");
        end
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        while (!hold_ready) @(negedge clk);
        #1;
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        check("R6", hold_ready, 1'b0, "ready after write");
        #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_empty();
        @(negedge clk);
        while (!tx_empty) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", txd, 1'b1, "txd in reset");
        check("R1", hold_ready, 1'b1, "ready in reset");
        check("R1", tx_empty, 1'b1, "empty in reset");
        #1 rst = 1'b0;

        tag = "R2";
        put(8'hA5);
        wait_empty();
        put(8'h01);
        wait_empty();

        tag = "R3";
        par_en = 1'b1; par_odd = 1'b0;
        put(8'h37);
        wait_empty();
        par_odd = 1'b1;
        put(8'h37);
        put(8'h00);
        wait_empty();
        par_en = 1'b0;

        tag = "R4";
        guard_len = 8'd4;
        put(8'h3C);
        put(8'hC3);
        wait_empty();

        tag = "R5";
        guard_len = 8'd0;
        put(8'h11);
        put(8'h22);
        put(8'h33);
        wait_empty();

        tag = "R7";
        put(8'h5A);
        #1 wr_en = 1'b1; wr_data = 8'hFF;
        @(negedge clk);
        check("R7", hold_ready, 1'b0, "ready after refused write");
        #1 wr_en = 1'b0;
        wait_empty();

        tag = "R8";
        guard_len = 8'd6;
        put(8'h81);
        repeat (60) @(negedge clk);
        check("R8", tx_empty, 1'b0, "empty inside gap");
        wait_empty();

        tag = "R9";
        guard_len = 8'd2;
        tick_period = 7;
        put(8'h96);
        tick_period = 2;
        put(8'h69);
        tick_period = 5;
        wait_empty();
        tick_period = 4;

        tag = "R10";
        guard_len = 8'd255;
        put(8'hE7);
        put(8'h18);
        wait_empty();
        guard_len = 8'd0;

        repeat (10) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule